// File: doc/BRIEF.md
# MMU Fault Status and Trap Decision Unit

This block keeps the fault record of a memory management unit. When the memory system reports an access that hit no mapped target, it presents the faulting address together with four qualifiers: write, instruction fetch, supervisor mode and alternate-space access. In the same clock edge the block folds the event into a 32-bit fault status word and captures the address in a fault address register. One cycle later it decides whether the processor must take an instruction-access trap or a data-access trap. That decision depends on two bits of the MMU control register: the translation enable bit and the no-fault bit.

Software reaches four registers through a small register port. The register is selected by address bits 11:8. Reading the status word returns it and clears it, so a second fault that arrives before software has looked at the first one is marked as an overflow. Writes to the control register change only the enable, no-fault and boot-mode bits. A write to the control or context register that really changes the stored value raises a one-cycle request to flush cached translations.

Top module: `mmu_fault_unit`

## Requirements
- R1: After reset, `sw_rdata`, `trap_code`, `trap_data` and `flush_req` are 0. The control register reads as the parameter `CTRL_RST` (default 32'h0500_0000). The context, fault status and fault address registers read as 0.
- R2: A fault seen while the status word is zero leaves the status word as follows. Bits 4:2 hold fault type 5. Bit 1 (address valid) is 1. Bit 16 equals the alternate-space qualifier, bit 5 the supervisor qualifier, bit 6 the fetch qualifier and bit 7 the write qualifier. Every other bit is 0.
- R3: A fault that arrives while the status word is non-zero first replaces the word with the value 1 (overflow, bit 0), then sets the bits of R2 on top of it.
- R4: Every fault stores `flt_addr` into the fault address register, whatever the control register holds.
- R5: One cycle after a fault, exactly one trap output pulses when control bit 0 (enable) is 1 and control bit 1 (no-fault) is 0. The output is `trap_code` for a fetch fault and `trap_data` otherwise. In all other cases neither output rises. A cycle with no fault produces no trap.
- R6: A read places the selected register on `sw_rdata` one cycle later, and `sw_rdata` holds its value until the next read. A read of the status register (index 3) clears it to zero.
- R7: A fault in the same cycle as a status read wins. The read returns the pre-fault word. The status word takes the fault value, and the overflow decision for that value uses the pre-fault word.
- R8: A write to index 0 (control) changes only bits 0 (enable), 1 (no-fault) and 14 (boot mode). Every other control bit keeps its value.
- R9: The index decode is as follows: 0 is control, 2 is context, 3 is fault status and 4 is fault address. Any other index reads as zero. Writes to indices 3 and 4 and to any unused index change no register.
- R10: `flush_req` pulses one cycle after a write to the control or context register that changes the stored value. It stays 0 after a write that leaves the value unchanged.
- R11: A write to index 2 stores all 32 bits of `sw_wdata` into the context register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_valid | input | 1 | Fault event in this cycle |
| flt_addr | input | 32 | Faulting address |
| flt_write | input | 1 | Fault qualifier: store access |
| flt_exec | input | 1 | Fault qualifier: instruction fetch |
| flt_super | input | 1 | Fault qualifier: supervisor mode |
| flt_asi | input | 1 | Fault qualifier: alternate-space access |
| sw_rd | input | 1 | Register read strobe |
| sw_wr | input | 1 | Register write strobe |
| sw_reg_addr | input | 4 | Register address bits 11:8 (register index) |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, valid the cycle after `sw_rd` |
| trap_code | output | 1 | Instruction-access trap pulse |
| trap_data | output | 1 | Data-access trap pulse |
| flush_req | output | 1 | Translation flush request pulse |

## Verification
A wrong fault status word is hidden until software reads index 3. It then shows on `sw_rdata` one cycle after the read, and it also leaves behind a wrong overflow decision for the next fault. A wrong control register value shows up sooner: the very next fault raises a missing or spurious trap one cycle later, or a control write causes a flush pulse that should not happen or fails to cause one that should. The bench therefore reads the status word right after single, repeated and same-cycle faults. It also compares traps and flushes against its own model on every clock.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

  localparam int STAT_W = 32;

  // Status word bit positions
  localparam int ST_OVF    = 0;
  localparam int ST_AVALID = 1;
  localparam int ST_FT_LSB = 2;
  localparam int ST_SUPER  = 5;
  localparam int ST_EXEC   = 6;
  localparam int ST_WRITE  = 7;
  localparam int ST_ASI    = 16;

  localparam logic [2:0] FTYPE_UNMAPPED = 3'd5;

  // Register indices
  localparam int IDX_CTRL = 0;
  localparam int IDX_CTX  = 2;
  localparam int IDX_STAT = 3;
  localparam int IDX_FADR = 4;

  typedef struct packed {
    logic asi;
    logic sup;
    logic exe;
    logic wr;
  } fault_qual_t;

  // Builds the status word that a new fault leaves behind.
  function automatic logic [STAT_W-1:0] fsr_compose(
    input logic [STAT_W-1:0] cur,
    input fault_qual_t       q
  );
    logic [STAT_W-1:0] r;
    r = '0;
    if (cur != '0) r[ST_OVF] = 1'b1;
    r[ST_ASI]                = q.asi;
    r[ST_SUPER]              = q.sup;
    r[ST_EXEC]               = q.exe;
    r[ST_WRITE]              = q.wr;
    r[ST_FT_LSB +: 3]        = FTYPE_UNMAPPED;
    r[ST_AVALID]             = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flt_valid,
  input  logic [ADDR_W-1:0]    flt_addr,
  input  fault_qual_t          flt_qual,
  input  logic                 stat_clr,
  output logic [STAT_W-1:0]    stat_q,
  output logic [ADDR_W-1:0]    fadr_q
);

  logic [STAT_W-1:0] stat_fault_val;
  assign stat_fault_val = fsr_compose(stat_q, flt_qual);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      fadr_q <= '0;
    end else begin
      if (flt_valid) begin
        stat_q <= stat_fault_val;
        fadr_q <= flt_addr;
      end else if (stat_clr) begin
        stat_q <= '0;
      end
    end
  end

  AST_FAULT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (stat_q[4:1] == 4'b1011)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && stat_q == '0) |=> !stat_q[ST_OVF]); // R2
  AST_OVERFLOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && stat_q != '0) |=> stat_q[ST_OVF]); // R3
  AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (fadr_q == $past(flt_addr))); // R4
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !flt_valid) |=> (stat_q == '0)); // R6
  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && flt_valid) |=> (stat_q != '0)); // R7

endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs #(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] CTRL_RST = '0,
  parameter int                EN_BIT   = 0,
  parameter int                NF_BIT   = 1,
  parameter int                BM_BIT   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_ctx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ctx_q,
  output logic              flush_req
);

  localparam logic [DATA_W-1:0] WMASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << NF_BIT) | (DATA_W'(1) << BM_BIT);

  logic [DATA_W-1:0] ctrl_nx;
  logic [DATA_W-1:0] ctx_nx;
  logic              value_changed;

  for (genvar g = 0; g < DATA_W; g++) begin : g_ctrl_bit
    if (WMASK[g]) begin : g_writable
      assign ctrl_nx[g] = wr_ctrl ? wdata[g] : ctrl_q[g];
    end else begin : g_fixed
      assign ctrl_nx[g] = ctrl_q[g];
    end
  end

  assign ctx_nx        = wr_ctx ? wdata : ctx_q;
  assign value_changed = (ctrl_nx != ctrl_q) || (ctx_nx != ctx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      ctx_q     <= '0;
      flush_req <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_nx;
      ctx_q     <= ctx_nx;
      flush_req <= value_changed;
    end
  end

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ((ctrl_q & ~WMASK) == ($past(ctrl_q) & ~WMASK))); // R8
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !wr_ctx) |=> !flush_req); // R10
  AST_FLUSH_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ($past(ctrl_q) != ctrl_q || $past(ctx_q) != ctx_q)); // R10
  AST_CTX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctx |=> (ctx_q == $past(wdata))); // R11

endmodule

// File: rtl/mmu_trap_gen.sv
module mmu_trap_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_valid,
  input  logic flt_exec,
  input  logic mmu_en,
  input  logic no_fault,
  output logic trap_code,
  output logic trap_data
);

  logic trap_armed;
  assign trap_armed = flt_valid && mmu_en && !no_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_code <= 1'b0;
      trap_data <= 1'b0;
    end else begin
      trap_code <= trap_armed && flt_exec;
      trap_data <= trap_armed && !flt_exec;
    end
  end

  AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_code, trap_data})); // R5
  AST_TRAP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_valid || !mmu_en || no_fault) |=> (!trap_code && !trap_data)); // R5
  AST_TRAP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    trap_code |-> $past(flt_exec)); // R5

endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit
  import mmu_fault_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 32,
  parameter int                IDX_LSB  = 8,
  parameter int                IDX_W    = 4,
  parameter logic [DATA_W-1:0] CTRL_RST = 32'h0500_0000,
  parameter int                EN_BIT   = 0,
  parameter int                NF_BIT   = 1,
  parameter int                BM_BIT   = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flt_valid,
  input  logic [ADDR_W-1:0]            flt_addr,
  input  logic                         flt_write,
  input  logic                         flt_exec,
  input  logic                         flt_super,
  input  logic                         flt_asi,
  input  logic                         sw_rd,
  input  logic                         sw_wr,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] sw_reg_addr,
  input  logic [DATA_W-1:0]            sw_wdata,
  output logic [DATA_W-1:0]            sw_rdata,
  output logic                         trap_code,
  output logic                         trap_data,
  output logic                         flush_req
);

  logic [IDX_W-1:0]  reg_idx;
  logic              sel_ctrl, sel_ctx, sel_stat, sel_fadr;
  logic              wr_ctrl, wr_ctx, stat_clr;
  fault_qual_t       qual;
  logic [DATA_W-1:0] ctrl_q, ctx_q, rd_mux;
  logic [STAT_W-1:0] stat_q;
  logic [ADDR_W-1:0] fadr_q;

  assign reg_idx  = sw_reg_addr;
  assign sel_ctrl = (reg_idx == IDX_W'(IDX_CTRL));
  assign sel_ctx  = (reg_idx == IDX_W'(IDX_CTX));
  assign sel_stat = (reg_idx == IDX_W'(IDX_STAT));
  assign sel_fadr = (reg_idx == IDX_W'(IDX_FADR));

  assign wr_ctrl  = sw_wr && sel_ctrl;
  assign wr_ctx   = sw_wr && sel_ctx;
  assign stat_clr = sw_rd && sel_stat;

  assign qual = '{asi: flt_asi, sup: flt_super, exe: flt_exec, wr: flt_write};

  mmu_ctrl_regs #(
    .DATA_W(DATA_W), .CTRL_RST(CTRL_RST),
    .EN_BIT(EN_BIT), .NF_BIT(NF_BIT), .BM_BIT(BM_BIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_ctx(wr_ctx),
    .wdata(sw_wdata), .ctrl_q(ctrl_q), .ctx_q(ctx_q), .flush_req(flush_req)
  );

  mmu_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_qual(qual), .stat_clr(stat_clr), .stat_q(stat_q), .fadr_q(fadr_q)
  );

  mmu_trap_gen u_trap (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_exec(flt_exec),
    .mmu_en(ctrl_q[EN_BIT]), .no_fault(ctrl_q[NF_BIT]),
    .trap_code(trap_code), .trap_data(trap_data)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) rd_mux = ctrl_q;
    if (sel_ctx)  rd_mux = ctx_q;
    if (sel_stat) rd_mux = DATA_W'(stat_q);
    if (sel_fadr) rd_mux = DATA_W'(fadr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_rdata <= '0;
    else if (sw_rd) sw_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rd |=> $stable(sw_rdata)); // R6
  AST_UNUSED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !sel_ctrl && !sel_ctx && !sel_stat && !sel_fadr) |=> (sw_rdata == '0)); // R9

endmodule

// File: tb/mmu_fault_unit_test.sv
module mmu_fault_unit_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] CTRL_RST   = 32'h0500_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0, flt_write = 1'b0, flt_exec = 1'b0;
  logic        flt_super = 1'b0, flt_asi = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        sw_rd = 1'b0, sw_wr = 1'b0;
  logic [11:8] sw_reg_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        trap_code, trap_data, flush_req;

  mmu_fault_unit #(.CTRL_RST(CTRL_RST)) uut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_write(flt_write), .flt_exec(flt_exec), .flt_super(flt_super),
    .flt_asi(flt_asi), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_reg_addr(sw_reg_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .trap_code(trap_code),
    .trap_data(trap_data), .flush_req(flush_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [31:0] m_ctrl = CTRL_RST, m_ctx = '0, m_stat = '0, m_far = '0;
  logic [31:0] m_rdata = '0;
  logic        m_tc = 1'b0, m_td = 1'b0, m_fl = 1'b0;
  string       m_rtag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive inputs, advance model, compare after the edge.
  task automatic cyc(input logic fv, input logic [31:0] fa, input logic fw,
                     input logic fe, input logic fs, input logic fq,
                     input logic rd, input logic wr, input int idx,
                     input logic [31:0] wd);
    logic [31:0] n_stat, n_ctrl;
    flt_valid = fv; flt_addr = fa; flt_write = fw; flt_exec = fe;
    flt_super = fs; flt_asi = fq; sw_rd = rd; sw_wr = wr;
    sw_reg_addr = 4'(idx); sw_wdata = wd;

    if (rd) begin
      case (idx)
        0: begin m_rdata = m_ctrl; m_rtag = "R8"; end
        2: begin m_rdata = m_ctx;  m_rtag = "R11"; end
        3: begin m_rdata = m_stat; m_rtag = "R6"; end
        4: begin m_rdata = m_far;  m_rtag = "R4"; end
        default: begin m_rdata = 32'h0; m_rtag = "R9"; end
      endcase
    end
    m_tc = fv && m_ctrl[0] && !m_ctrl[1] && fe;
    m_td = fv && m_ctrl[0] && !m_ctrl[1] && !fe;
    m_fl = 1'b0;
    n_stat = m_stat;
    if (rd && idx == 3) n_stat = 32'h0;
    if (fv) begin
      n_stat = (m_stat != 0) ? 32'h1 : 32'h0;
      n_stat = n_stat + 32'h16 + (32'(fq) << 16) + (32'(fs) << 5)
             + (32'(fe) << 6) + (32'(fw) << 7);
      m_far = fa;
    end
    m_stat = n_stat;
    if (wr && idx == 0) begin
      n_ctrl = (m_ctrl & 32'hFFFF_BFFC) | (wd & 32'h0000_4003);
      m_fl = (n_ctrl != m_ctrl);
      m_ctrl = n_ctrl;
    end
    if (wr && idx == 2) begin
      m_fl = (wd != m_ctx);
      m_ctx = wd;
    end

    @(negedge clk);
    chk(m_rtag, sw_rdata, m_rdata);
    chk("R5 trap_code", 32'(trap_code), 32'(m_tc));
    chk("R5 trap_data", 32'(trap_data), 32'(m_td));
    chk("R10 flush", 32'(flush_req), 32'(m_fl));
  endtask

  task automatic idle();             cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(input int idx);  cyc(0, 0, 0, 0, 0, 0, 1, 0, idx, 0); endtask
  task automatic wr(input int idx, input logic [31:0] d); cyc(0, 0, 0, 0, 0, 0, 0, 1, idx, d); endtask
  task automatic flt(input logic [31:0] a, input logic w, input logic e,
                     input logic s, input logic q);
    cyc(1, a, w, e, s, q, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the run ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", sw_rdata, 32'h0);
    chk("R1 trap", {30'h0, trap_code, trap_data}, 32'h0);
    chk("R1 flush", 32'(flush_req), 32'h0);
    rd(0); chk("R1 ctrl", sw_rdata, CTRL_RST);
    rd(2); chk("R1 ctx", sw_rdata, 32'h0);
    rd(3); chk("R1 stat", sw_rdata, 32'h0);
    rd(4); chk("R1 fadr", sw_rdata, 32'h0);

    // R8 / R10 control write masking and flush
    wr(0, 32'hFFFF_FFFF); chk("R10 change", 32'(flush_req), 32'h1);
    rd(0); chk("R8 mask", sw_rdata, 32'h0500_4003);
    wr(0, 32'h0000_4003); chk("R10 same", 32'(flush_req), 32'h0);
    wr(0, 32'h0000_0001);

    // R2 / R4 / R5 / R6
    flt(32'hA000_1234, 1, 0, 0, 1);
    chk("R5 data trap", {30'h0, trap_code, trap_data}, 32'h1);
    rd(3); chk("R2 status", sw_rdata, 32'h0001_0096);
    rd(4); chk("R4 fadr", sw_rdata, 32'hA000_1234);
    rd(3); chk("R6 cleared", sw_rdata, 32'h0);

    // R3 overflow
    flt(32'h0000_0010, 0, 1, 0, 0);
    chk("R5 code trap", {30'h0, trap_code, trap_data}, 32'h2);
    flt(32'h0000_0020, 0, 0, 1, 0);
    rd(3); chk("R3 overflow", sw_rdata, 32'h0000_0037);
    rd(4); chk("R4 second", sw_rdata, 32'h0000_0020);

    // R7 fault and read in the same cycle
    flt(32'h0000_0030, 0, 0, 0, 0);
    cyc(1, 32'h0000_0040, 0, 1, 0, 0, 1, 0, 3, 0);
    chk("R7 pre-fault", sw_rdata, 32'h0000_0016);
    rd(3); chk("R7 fault kept", sw_rdata, 32'h0000_0057);

    // R5 suppression
    wr(0, 32'h0000_0003);
    flt(32'h0000_0050, 0, 0, 0, 0);
    chk("R5 no-fault", {30'h0, trap_code, trap_data}, 32'h0);
    wr(0, 32'h0000_0000);
    flt(32'h0000_0060, 0, 1, 0, 0);
    chk("R5 disabled", {30'h0, trap_code, trap_data}, 32'h0);
    rd(4); chk("R4 no trap", sw_rdata, 32'h0000_0060);

    // R9 / R11 index decode
    rd(3);
    wr(3, 32'hFFFF_FFFF); rd(3); chk("R9 stat ro", sw_rdata, 32'h0);
    wr(4, 32'h1234_5678); rd(4); chk("R9 fadr ro", sw_rdata, 32'h0000_0060);
    wr(7, 32'hFFFF_FFFF); rd(7); chk("R9 unused", sw_rdata, 32'h0);
    wr(2, 32'hDEAD_BEEF); chk("R10 ctx change", 32'(flush_req), 32'h1);
    rd(2); chk("R11 ctx", sw_rdata, 32'hDEAD_BEEF);
    wr(2, 32'hDEAD_BEEF); chk("R10 ctx same", 32'(flush_req), 32'h0);
    idle();

    // Mixed traffic against the model
    for (int i = 0; i < 500; i++) begin
      int pick;
      int idx_tab[6] = '{0, 2, 3, 4, 7, 1};
      pick = $urandom_range(0, 5);
      cyc(1'($urandom_range(0, 2) == 0), $urandom, 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 3) == 0), idx_tab[pick],
          ($urandom_range(0, 1) == 0) ? $urandom : {30'h0, 2'($urandom)});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule